// File: doc/BRIEF.md
# Receive Frame Pulse Generator

This block drives the receive-side system frame indication for a single E1 or T1/J1 bit stream. Three counters track the stream: a bit position inside the frame, a frame index inside the CRC multiframe and a frame index inside the signaling multiframe (or the T1/J1 superframe). All of them advance only on clock cycles where the bit strobe `bit_en` is high. Each strobe stands for one bit period of the line, so the block can run from any clock faster than the bit rate.

The framer that feeds the block supplies three alignment markers, each sampled together with a strobe. `frm_mark` says the strobed bit is bit 0 of a frame. `crc_mark` and `sig_mark` say the frame beginning at this bit is frame 0 of a multiframe. From the counters and the markers the block places one registered output, `fp_out`. Depending on the configuration it shows every frame start, a multiframe start, or, in E1, a level that two independent multiframe boundaries set and clear.

The line mode and the pulse type can change at any time but only take effect at a frame start. This keeps the output free of shortened pulses. Polarity is a static strap that selects which level counts as active.

Top module: `rx_frame_pulse_gen`

## Requirements
- R1: With `line_mode`=0 (E1, 256-bit frames) and `pulse_sel`=0, the output is active for exactly the strobe period of bit 0 of every frame and inactive for every other strobe.
- R2: With E1 and `pulse_sel`=1, the output is active only for bit 0 of frame 0 of each 16-frame CRC multiframe, counted from the frame at which `crc_mark` was accepted.
- R3: With E1 and `pulse_sel`=2, the output is active only for bit 0 of frame 0 of each 16-frame signaling multiframe, counted from the frame at which `sig_mark` was accepted.
- R4: With E1 and `pulse_sel`=3, the output becomes active on bit 0 of a signaling multiframe start. It becomes inactive on the strobe that follows bit 0 of a CRC multiframe start, and holds its level otherwise.
- R5: With `line_mode`=1 (T1/J1, 193-bit frames, bit 0 is the F-bit) and `pulse_sel`=0 or 3, the output is active for every F-bit.
- R6: With T1/J1, `pulse_sel`=1 marks the first F-bit of each 12-frame superframe and `pulse_sel`=2 marks the first F-bit of each 24-frame superframe. Both are counted from the frame at which `sig_mark` was accepted.
- R7: `pol_high`=1 makes the active level 1, and `pol_high`=0 makes it 0.
- R8: The counters and the output change only at clock edges where `bit_en` is high. Between strobes the output holds.
- R9: After reset, and until `frm_mark` has been accepted, the output stays at its inactive level.
- R10: `crc_mark` and `sig_mark` are accepted only on a strobe that falls on bit 0 of a frame. At any other bit they have no effect on the pulse positions.
- R11: A change of `line_mode` or `pulse_sel` takes effect from the next frame start. The frame in progress keeps its old behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit strobe: one high cycle per line bit period |
| frm_mark | input | 1 | The strobed bit is bit 0 of a frame |
| crc_mark | input | 1 | The frame starting at this bit is CRC multiframe frame 0 |
| sig_mark | input | 1 | The frame starting at this bit is signaling multiframe (or superframe) frame 0 |
| line_mode | input | 1 | 0 = E1, 1 = T1/J1 |
| pulse_sel | input | 2 | Pulse type select (see R1 to R6) |
| pol_high | input | 1 | 1 = active-high output, 0 = active-low |
| fp_out | output | 1 | Frame pulse or multiframe level |

## Verification
A wrong bit position puts a pulse at the wrong bit. This shows up on the output at the next frame start, at most one frame (256 or 193 strobes) later. A wrong multiframe index only shows up when the expected multiframe pulse is missing or misplaced, which can take up to 16 or 24 frames. A wrong combined level can stay hidden until the next signaling or CRC boundary. For this reason the bench compares the output with its own model after every clock and runs each multiframe mode across two or more boundaries.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

  typedef enum logic {
    LINE_E1 = 1'b0,
    LINE_T1 = 1'b1
  } line_e;

  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_MF_A  = 2'd1,
    SEL_MF_B  = 2'd2,
    SEL_MIXED = 2'd3
  } psel_e;

  typedef struct packed {
    line_e mode;
    psel_e sel;
  } fp_cfg_t;

endpackage

// File: rtl/rfp_rst_sync.sv
module rfp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/rfp_bit_ctr.sv
module rfp_bit_ctr
  import rfp_pkg::*;
#(
  parameter int E1_BITS = 256,
  parameter int T1_BITS = 193,
  parameter int POS_W   = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bit_en,
  input  logic    frm_mark,
  input  fp_cfg_t cfg_live,
  output fp_cfg_t cfg_eff,
  output logic    frame_start,
  output logic    aligned
);

  logic [POS_W-1:0] pos_q, pos_d, len_m1;
  logic             aligned_q, aligned_d;
  fp_cfg_t          cfg_q, cfg_d;
  logic             wrap;

  // next-state
  always_comb begin
    len_m1      = (cfg_q.mode == LINE_T1) ? POS_W'(T1_BITS - 1) : POS_W'(E1_BITS - 1);
    wrap        = (pos_q >= len_m1);
    pos_d       = pos_q;
    aligned_d   = aligned_q;
    cfg_d       = cfg_q;
    frame_start = 1'b0;
    if (bit_en) begin
      pos_d       = (frm_mark || wrap) ? '0 : pos_q + 1'b1;
      aligned_d   = aligned_q | frm_mark;
      frame_start = frm_mark | (aligned_q & wrap);
      if (frm_mark || wrap) begin
        cfg_d = cfg_live;
      end
    end
    // a new configuration governs the frame starting on this very bit
    cfg_eff = frame_start ? cfg_live : cfg_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      aligned_q <= 1'b0;
      cfg_q     <= '0;
    end else if (bit_en) begin
      pos_q     <= pos_d;
      aligned_q <= aligned_d;
      cfg_q     <= cfg_d;
    end
  end

  assign aligned = aligned_q;

  // R8
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pos_q) && $stable(cfg_q));

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= len_m1);

endmodule

// File: rtl/rfp_mf_ctr.sv
module rfp_mf_ctr #(
  parameter int CNT_W      = 5,
  parameter int MAX_FRAMES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             mark,
  input  logic [CNT_W-1:0] last_idx,
  output logic             mf_start,
  output logic             ok
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ok_q, ok_d;
  logic             wrap;

  // next-state
  always_comb begin
    wrap     = (cnt_q >= last_idx);
    cnt_d    = (mark || wrap) ? '0 : cnt_q + 1'b1;
    ok_d     = ok_q | mark;
    mf_start = step & (mark | (ok_q & wrap));
  end

  // registers, advanced once per frame start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign ok = ok_q;

  // R10
  mf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q) && $stable(ok_q));

  // R10
  mf_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_FRAMES));

endmodule

// File: rtl/rfp_pulse_out.sv
module rfp_pulse_out
  import rfp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bit_en,
  input  logic    frm_ok,
  input  fp_cfg_t cfg_eff,
  input  logic    frame_start,
  input  logic    crc_start,
  input  logic    sig_start,
  input  logic    pol_high,
  output logic    fp_out
);

  logic act_q, act_d;
  logic lvl_q, lvl_d;
  logic crc_prev_q;

  // next-state
  always_comb begin
    lvl_d = lvl_q;
    if (sig_start) begin
      lvl_d = 1'b1;
    end else if (crc_prev_q) begin
      lvl_d = 1'b0;
    end

    if (cfg_eff.mode == LINE_E1) begin
      case (cfg_eff.sel)
        SEL_FRAME: act_d = frame_start;
        SEL_MF_A:  act_d = crc_start;
        SEL_MF_B:  act_d = sig_start;
        default:   act_d = lvl_d;
      endcase
    end else begin
      case (cfg_eff.sel)
        SEL_MF_A, SEL_MF_B: act_d = sig_start;
        default:            act_d = frame_start;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      lvl_q      <= 1'b0;
      crc_prev_q <= 1'b0;
    end else if (bit_en) begin
      act_q      <= act_d;
      lvl_q      <= lvl_d;
      crc_prev_q <= crc_start;
    end
  end

  assign fp_out = pol_high ? act_q : ~act_q;

  // R9
  idle_until_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_ok |-> !act_q);

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(act_q));

  // R4
  lvl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> $past(sig_start));

endmodule

// File: rtl/rx_frame_pulse_gen.sv
module rx_frame_pulse_gen
  import rfp_pkg::*;
#(
  parameter int E1_FRAME_BITS = 256,
  parameter int T1_FRAME_BITS = 193,
  parameter int E1_MF_FRAMES  = 16,
  parameter int T1_SF_FRAMES  = 12,
  parameter int T1_ESF_FRAMES = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       frm_mark,
  input  logic       crc_mark,
  input  logic       sig_mark,
  input  logic       line_mode,
  input  logic [1:0] pulse_sel,
  input  logic       pol_high,
  output logic       fp_out
);

  localparam int MAX_BITS   = (E1_FRAME_BITS > T1_FRAME_BITS) ? E1_FRAME_BITS : T1_FRAME_BITS;
  localparam int POS_W      = $clog2(MAX_BITS);
  localparam int MF_MAX_A   = (E1_MF_FRAMES > T1_SF_FRAMES) ? E1_MF_FRAMES : T1_SF_FRAMES;
  localparam int MF_MAX     = (MF_MAX_A > T1_ESF_FRAMES) ? MF_MAX_A : T1_ESF_FRAMES;
  localparam int MF_W       = $clog2(MF_MAX);
  localparam int N_MF       = 2;

  logic    rst_int_n;
  fp_cfg_t cfg_live, cfg_eff;
  logic    frame_start, aligned;
  logic [N_MF-1:0]  mf_mark_v, mf_start_v, mf_ok_v;
  logic [MF_W-1:0]  mf_last_v [N_MF];

  assign cfg_live.mode = line_e'(line_mode);
  assign cfg_live.sel  = psel_e'(pulse_sel);

  rfp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rfp_bit_ctr #(
    .E1_BITS (E1_FRAME_BITS),
    .T1_BITS (T1_FRAME_BITS),
    .POS_W   (POS_W)
  ) u_bits (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bit_en      (bit_en),
    .frm_mark    (frm_mark),
    .cfg_live    (cfg_live),
    .cfg_eff     (cfg_eff),
    .frame_start (frame_start),
    .aligned     (aligned)
  );

  // index 0: CRC multiframe, index 1: signaling multiframe / superframe
  assign mf_mark_v[0] = crc_mark;
  assign mf_mark_v[1] = sig_mark;
  assign mf_last_v[0] = MF_W'(E1_MF_FRAMES - 1);
  assign mf_last_v[1] = (cfg_eff.mode == LINE_E1) ? MF_W'(E1_MF_FRAMES - 1) :
                        (cfg_eff.sel == SEL_MF_B) ? MF_W'(T1_ESF_FRAMES - 1) :
                                                    MF_W'(T1_SF_FRAMES - 1);

  for (genvar k = 0; k < N_MF; k++) begin : g_mf
    rfp_mf_ctr #(
      .CNT_W      (MF_W),
      .MAX_FRAMES (MF_MAX)
    ) u_mf (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .step     (frame_start),
      .mark     (mf_mark_v[k]),
      .last_idx (mf_last_v[k]),
      .mf_start (mf_start_v[k]),
      .ok       (mf_ok_v[k])
    );
  end

  rfp_pulse_out u_out (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bit_en      (bit_en),
    .frm_ok      (aligned),
    .cfg_eff     (cfg_eff),
    .frame_start (frame_start),
    .crc_start   (mf_start_v[0]),
    .sig_start   (mf_start_v[1]),
    .pol_high    (pol_high),
    .fp_out      (fp_out)
  );

  // R10
  mf_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mf_start_v[0] && !crc_mark) |-> mf_ok_v[0]);

endmodule

// File: tb/tb_rx_frame_pulse_gen.sv
`timescale 1ns/1ps
module tb_rx_frame_pulse_gen;

  logic clk, rst_n, bit_en, frm_mark, crc_mark, sig_mark, line_mode, pol_high;
  logic [1:0] pulse_sel;
  logic fp_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  int n, crc_f0, sig_f0, fsel, lsel, mode_i;
  bit al, lvl, pcrc, exp_act, pol_b;

  rx_frame_pulse_gen dut (
    .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .frm_mark (frm_mark),
    .crc_mark (crc_mark), .sig_mark (sig_mark), .line_mode (line_mode),
    .pulse_sel (pulse_sel), .pol_high (pol_high), .fp_out (fp_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<190000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic model_reset(input int md, input int sel, input bit pol);
    n = 0; crc_f0 = -1; sig_f0 = -1; fsel = sel; lsel = sel; mode_i = md;
    al = 0; lvl = 0; pcrc = 0; exp_act = 0; pol_b = pol;
  endtask

  task automatic model_step(input bit fm, input bit cm, input bit sm);
    int flen, pos, f, m;
    bit con, son;
    if (fm) begin al = 1; n = 0; end
    else if (al) n++;
    if (!al) begin exp_act = 0; pcrc = 0; return; end
    flen = (mode_i != 0) ? 193 : 256;
    pos = n % flen;
    f = n / flen;
    if (pos == 0) begin
      fsel = lsel;
      if (cm) crc_f0 = f;
      if (sm) sig_f0 = f;
    end
    m = (mode_i != 0) ? ((fsel == 2) ? 24 : 12) : 16;
    con = (pos == 0) && (crc_f0 >= 0) && (((f - crc_f0) % 16) == 0);
    son = (pos == 0) && (sig_f0 >= 0) && (((f - sig_f0) % m) == 0);
    if (son) lvl = 1;
    else if (pcrc) lvl = 0;
    pcrc = con;
    if (mode_i == 0) begin
      case (fsel)
        0: exp_act = (pos == 0);
        1: exp_act = con;
        2: exp_act = son;
        default: exp_act = lvl;
      endcase
    end else begin
      exp_act = (fsel == 1 || fsel == 2) ? son : (pos == 0);
    end
  endtask

  task automatic check_out(input string tag);
    logic want;
    want = pol_b ? exp_act : ~exp_act;
    checks++;
    if (fp_out !== want) begin
      errors++;
      $display("FAIL %s at cycle %0d: fp_out=%0b expected=%0b", tag, cyc, fp_out, want);
    end
  endtask

  task automatic tick(input bit be, input bit fm, input bit cm, input bit sm, input string tag);
    bit_en = be; frm_mark = fm; crc_mark = cm; sig_mark = sm;
    @(posedge clk);
    if (be) model_step(fm, cm, sm);
    #1;
    check_out(tag);
    @(negedge clk);
  endtask

  task automatic run_case(input int md, input int sel, input bit pol, input int nfr,
                          input int cf, input int sf, input bit gap,
                          input int sw_f, input int sw_pos, input int sw_sel,
                          input int stray_f, input string tag);
    int flen;
    @(negedge clk);
    rst_n = 0; bit_en = 0; frm_mark = 0; crc_mark = 0; sig_mark = 0;
    line_mode = md[0]; pulse_sel = sel[1:0]; pol_high = pol;
    model_reset(md, sel, pol);
    repeat (3) @(negedge clk);
    check_out("R9 reset state");
    rst_n = 1;
    repeat (3) tick(0, 0, 0, 0, "R9 idle after reset");
    repeat (3) tick(1, 0, 0, 0, "R9 strobes before frame marker");
    flen = (md != 0) ? 193 : 256;
    for (int s = 0; s < nfr * flen; s++) begin
      int f, p;
      f = s / flen;
      p = s % flen;
      if (f == sw_f && p == sw_pos) begin
        pulse_sel = sw_sel[1:0];
        lsel = sw_sel;
      end
      if (gap && (s % 3 == 2)) tick(0, 0, 0, 0, "R8 hold between strobes");
      tick(1, (s == 0), ((p == 0) && (f == cf)) || ((f == stray_f) && (p == 5)),
           (p == 0) && (f == sf), tag);
    end
  endtask

  initial begin
    rst_n = 0; bit_en = 0; frm_mark = 0; crc_mark = 0; sig_mark = 0;
    line_mode = 0; pulse_sel = 0; pol_high = 1;
    // R1, R8: E1 basic frame pulse with strobe gaps
    run_case(0, 0, 1, 4, -1, -1, 1, -1, 0, 0, -1, "R1 E1 frame pulse");
    // R2, R7, R10: CRC multiframe, active-low, stray marker mid-frame
    run_case(0, 1, 0, 36, 1, -1, 0, -1, 0, 0, 4, "R2/R7/R10 E1 CRC multiframe");
    // R3: signaling multiframe
    run_case(0, 2, 1, 36, -1, 3, 0, -1, 0, 0, -1, "R3 E1 signaling multiframe");
    // R4, R11: combined level, then switched to frame pulses mid-frame
    run_case(0, 3, 1, 30, 1, 6, 0, 24, 100, 0, -1, "R4/R11 E1 combined level");
    // R5: T1 every F-bit with gaps
    run_case(1, 3, 1, 6, -1, -1, 1, -1, 0, 0, -1, "R5 T1 F-bit pulse");
    // R6: T1 12-frame superframe, active-low
    run_case(1, 1, 0, 30, -1, 2, 0, -1, 0, 0, -1, "R6 T1 12-frame superframe");
    // R6: T1 24-frame superframe
    run_case(1, 2, 1, 52, -1, 1, 0, -1, 0, 0, -1, "R6 T1 24-frame superframe");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule